// File: doc/BRIEF.md
# Quadrature Encoder Clock Converter

This block turns the two phase-shifted square waves of an incremental encoder into counting pulses that a plain up/down counter can take directly. Each encoder line is first brought into the system clock domain by a two-flop synchronizer. It then passes a per-line validation filter, which accepts a new level only after that level has held for a parameterised number of cycles. This rejects the dither an encoder shows when it rests on an edge.

A mode input selects the resolution. With `x4_sel` high, every accepted edge on either line counts. With it low, only one edge per full quadrature cycle counts. Both output styles are driven at the same time. The first is a pair of active-low strobes, one for up and one for down. The second is a single active-low counting clock together with a direction level.

The width of every pulse is a run-time count of system clock cycles. The direction level is set one cycle before the combined clock falls and is held past its rising edge, so a counter that counts on the rising edge always sees the correct direction. A transition that arrives while a pulse is still being emitted is held in a one-entry queue and emitted afterwards. A step in which both lines change at once is treated as illegal: it produces no pulse and raises a one-cycle error flag.

Top module: `quad_clk_conv`

## Requirements
- R1: A change on an encoder line is accepted only after the synchronized level has differed from the accepted level for FILT_LEN consecutive cycles. A raw excursion lasting fewer than FILT_LEN cycles produces no pulse; one lasting FILT_LEN cycles or more produces one.
- R2: With `x4_sel` = 1, every accepted single-line step produces exactly one pulse. The up order of the state {B,A} is 00, 01, 11, 10, 00. The reverse order is down.
- R3: With `x4_sel` = 0, an up pulse is issued only on the step {B,A} 00 to 01, and a down pulse only on the step 01 to 00. No other step produces a pulse, so there is one pulse per full quadrature cycle.
- R4: `up_n` goes low only for up steps and `dn_n` only for down steps. The two are never low at the same time.
- R5: `cnt_up` is 1 after an up pulse and 0 after a down pulse, and it keeps its value between pulses.
- R6: `cnt_clk_n` is low in exactly those cycles in which `up_n` or `dn_n` is low.
- R7: `cnt_up` does not change in the cycle in which `cnt_clk_n` falls. It is also stable while `cnt_clk_n` is low and in the cycle in which it rises.
- R8: Each low pulse lasts `pulse_len` cycles. A value of 0 is treated as 1.
- R9: A step accepted while a pulse is in progress is stored, one deep, and emitted after that pulse. It is never dropped.
- R10: A step in which both lines change in the same cycle produces no pulse and drives `seq_err` high for exactly one cycle.
- R11: During and after reset, `up_n`, `dn_n` and `cnt_clk_n` are 1, `cnt_up` is 1 and `seq_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw encoder line A, asynchronous |
| enc_b | input | 1 | Raw encoder line B, asynchronous |
| x4_sel | input | 1 | 1 selects x4 resolution, 0 selects x1 |
| pulse_len | input | PW_W | Output pulse width in cycles (0 acts as 1) |
| up_n | output | 1 | Active-low up strobe |
| dn_n | output | 1 | Active-low down strobe |
| cnt_clk_n | output | 1 | Active-low combined counting clock |
| cnt_up | output | 1 | Direction level, 1 means count up |
| seq_err | output | 1 | One-cycle flag for a step in which both lines change |

## Verification
The assertions assume three things about the inputs. Accepted steps must never come so fast that a third step arrives while one pulse is being emitted and another is already queued. `x4_sel` and `pulse_len` must stay steady while a pulse is in flight. Both lines must be low when reset is released. The stimulus meets these conditions in the following ways. Ordinary steps are spaced well beyond the filter delay plus the pulse length. Only the queue test places two steps three cycles apart, and it then waits for the output to drain. The mode and width are changed only after the outputs have gone idle. Each sequence returns the encoder to state 00 before the next one starts.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_SETUP = 2'd1,
    PG_LOW   = 2'd2
  } pg_state_t;

  typedef struct packed {
    logic valid;
    logic up;
  } qcc_event_t;

  // Successor of a {B,A} state when moving in the up direction.
  function automatic logic [1:0] step_fwd(input logic [1:0] s);
    logic [1:0] r;
    case (s)
      2'b00:   r = 2'b01;
      2'b01:   r = 2'b11;
      2'b11:   r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qcc_filter.sv
module qcc_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);

  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b00;
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level = level_q;

  // The accepted level may only move to the value the synchronizer held.
  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (level_q == $past(sync_q[1]))); // R1

endmodule

// File: rtl/qcc_decode.sv
module qcc_decode
  import qcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x4_sel,
  input  logic [1:0] lvl,
  output qcc_event_t ev,
  output logic       seq_err
);

  logic [1:0] prev_q;
  qcc_event_t ev_d, ev_q;
  logic       err_d, err_q;
  logic [1:0] diff;
  logic       fwd, bwd;

  always_comb begin
    diff     = lvl ^ prev_q;
    fwd      = (lvl == step_fwd(prev_q));
    bwd      = (prev_q == step_fwd(lvl));
    err_d    = (diff == 2'b11);
    ev_d     = '0;
    if (x4_sel) begin
      ev_d.valid = fwd | bwd;
      ev_d.up    = fwd;
    end else begin
      if (prev_q == 2'b00 && lvl == 2'b01) begin
        ev_d.valid = 1'b1;
        ev_d.up    = 1'b1;
      end else if (prev_q == 2'b01 && lvl == 2'b00) begin
        ev_d.valid = 1'b1;
        ev_d.up    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 2'b00;
      ev_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      ev_q   <= ev_d;
      err_q  <= err_d;
    end
  end

  assign ev      = ev_q;
  assign seq_err = err_q;

  AST_ERR_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !ev.valid); // R10

  AST_X1_A_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ev_d.valid && !x4_sel) |-> (lvl[1] == 1'b0 && prev_q[1] == 1'b0)); // R3

endmodule

// File: rtl/qcc_pulse.sv
module qcc_pulse
  import qcc_pkg::*;
#(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  qcc_event_t      ev_i,
  input  logic [PW_W-1:0] pulse_len,
  output logic            up_n,
  output logic            dn_n,
  output logic            clk_n,
  output logic            dir
);

  pg_state_t       state_q;
  logic [PW_W-1:0] left_q;
  logic            pend_v_q, pend_up_q;
  logic            dir_q, up_n_q, dn_n_q, clk_n_q;
  logic            start;
  logic            src_up;
  logic [PW_W-1:0] eff_len;

  always_comb begin
    start   = (state_q == PG_IDLE) && (pend_v_q || ev_i.valid);
    src_up  = pend_v_q ? pend_up_q : ev_i.up;
    eff_len = (pulse_len == '0) ? PW_W'(1) : pulse_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PG_IDLE;
      left_q    <= '0;
      pend_v_q  <= 1'b0;
      pend_up_q <= 1'b0;
      dir_q     <= 1'b1;
      up_n_q    <= 1'b1;
      dn_n_q    <= 1'b1;
      clk_n_q   <= 1'b1;
    end else begin
      case (state_q)
        PG_IDLE: begin
          if (start) begin
            state_q <= PG_SETUP;
            dir_q   <= src_up;
          end
        end
        PG_SETUP: begin
          state_q <= PG_LOW;
          clk_n_q <= 1'b0;
          up_n_q  <= ~dir_q;
          dn_n_q  <= dir_q;
          left_q  <= eff_len - 1'b1;
        end
        PG_LOW: begin
          if (left_q == '0) begin
            state_q <= PG_IDLE;
            clk_n_q <= 1'b1;
            up_n_q  <= 1'b1;
            dn_n_q  <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: state_q <= PG_IDLE;
      endcase

      if (start) begin
        pend_v_q  <= pend_v_q & ev_i.valid;
        pend_up_q <= ev_i.up;
      end else if (ev_i.valid) begin
        pend_v_q  <= 1'b1;
        pend_up_q <= ev_i.up;
      end
    end
  end

  assign up_n  = up_n_q;
  assign dn_n  = dn_n_q;
  assign clk_n = clk_n_q;
  assign dir   = dir_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!up_n && !dn_n)); // R4

  AST_CLK_COMBINED: assert property (@(posedge clk) disable iff (rst)
    clk_n == (up_n & dn_n)); // R6

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clk_n || $past(!clk_n)) |-> $stable(dir)); // R7

  AST_QUEUE_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (ev_i.valid && pend_v_q) |-> start); // R9

endmodule

// File: rtl/quad_clk_conv.sv
module quad_clk_conv
  import qcc_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8,
  parameter int unsigned PW_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic            x4_sel,
  input  logic [PW_W-1:0] pulse_len,
  output logic            up_n,
  output logic            dn_n,
  output logic            cnt_clk_n,
  output logic            cnt_up,
  output logic            seq_err
);

  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] lvl_vec;
  qcc_event_t        ev;

  assign raw_vec = {enc_b, enc_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_line
    qcc_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_vec[ch]),
      .level (lvl_vec[ch])
    );
  end

  qcc_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .x4_sel  (x4_sel),
    .lvl     (lvl_vec),
    .ev      (ev),
    .seq_err (seq_err)
  );

  qcc_pulse #(.PW_W(PW_W)) u_pg (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (ev),
    .pulse_len (pulse_len),
    .up_n      (up_n),
    .dn_n      (dn_n),
    .clk_n     (cnt_clk_n),
    .dir       (cnt_up)
  );

endmodule

// File: tb/quad_clk_conv_test.sv
`timescale 1ns/1ps
module quad_clk_conv_test;

  localparam int unsigned FL = 4;
  localparam int unsigned PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enc_a = 1'b0, enc_b = 1'b0, x4_sel = 1'b1;
  logic [PW-1:0] pulse_len = 8'd2;
  logic          up_n, dn_n, cnt_clk_n, cnt_up, seq_err;

  int checks = 0, failures = 0;
  int n_up, n_dn, n_clk, n_err, err_long, width_bad, dir_bad, excl_bad, comb_bad;
  int low_len, exp_w;
  logic prev_clk = 1'b1, prev_dir = 1'b1, prev_err = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  quad_clk_conv #(.FILT_LEN(FL), .PW_W(PW)) uut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .x4_sel(x4_sel),
    .pulse_len(pulse_len), .up_n(up_n), .dn_n(dn_n), .cnt_clk_n(cnt_clk_n),
    .cnt_up(cnt_up), .seq_err(seq_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (!up_n && !dn_n) excl_bad++;
      if (cnt_clk_n != (up_n & dn_n)) comb_bad++;
      if (prev_clk && !cnt_clk_n) begin
        n_clk++;
        if (!up_n) n_up++;
        if (!dn_n) n_dn++;
        if (cnt_up != prev_dir) dir_bad++;
        low_len = 1;
      end else if (!prev_clk && !cnt_clk_n) begin
        low_len++;
        if (cnt_up != prev_dir) dir_bad++;
      end else if (!prev_clk && cnt_clk_n) begin
        if (low_len != exp_w) width_bad++;
        if (cnt_up != prev_dir) dir_bad++;
      end
      if (seq_err) begin
        if (!prev_err) n_err++;
        else err_long++;
      end
      prev_clk = cnt_clk_n;
      prev_dir = cnt_up;
      prev_err = seq_err;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    n_up = 0; n_dn = 0; n_clk = 0; n_err = 0; err_long = 0;
    width_bad = 0; dir_bad = 0; excl_bad = 0; comb_bad = 0;
  endtask

  task automatic step(input logic [1:0] s, input int gap);
    {enc_b, enc_a} = s;
    repeat (gap) @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] seq_at(input bit up, input int i);
    logic [1:0] u[4] = '{2'b01, 2'b11, 2'b10, 2'b00};
    logic [1:0] d[4] = '{2'b10, 2'b11, 2'b01, 2'b00};
    return up ? u[i] : d[i];
  endfunction

  task automatic run_seq(input bit mode, input bit up, input int ncyc, input int w);
    int exp_n;
    clr();
    x4_sel = mode;
    pulse_len = PW'(w);
    exp_w = (w == 0) ? 1 : w;
    for (int c = 0; c < ncyc; c++)
      for (int i = 0; i < 4; i++) step(seq_at(up, i), exp_w + 14);
    repeat (30) @(posedge clk);
    #1;
    exp_n = mode ? 4 * ncyc : ncyc;
    if (mode) check("R2", "x4 pulse count", n_clk, exp_n);
    else      check("R3", "x1 pulse count", n_clk, exp_n);
    check("R4", "strobe on correct line", up ? n_up : n_dn, exp_n);
    check("R4", "strobe on wrong line", up ? n_dn : n_up, 0);
    check("R4", "both strobes low", excl_bad, 0);
    check("R5", "direction level", int'(cnt_up), int'(up));
    check("R6", "combined clock mismatch", comb_bad, 0);
    check("R7", "direction moved near clock", dir_bad, 0);
    check("R8", "pulse width errors", width_bad, 0);
  endtask

  initial begin
    exp_w = 2;
    clr();
    repeat (3) @(posedge clk);
    #1;
    check("R11", "up_n in reset", int'(up_n), 1);
    check("R11", "cnt_clk_n in reset", int'(cnt_clk_n), 1);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R11", "dn_n after reset", int'(dn_n), 1);
    check("R11", "cnt_up after reset", int'(cnt_up), 1);
    check("R11", "seq_err after reset", int'(seq_err), 0);

    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int wi = 0; wi < 4; wi++) begin
          int wv[4] = '{0, 1, 3, 6};
          run_seq(bit'(m), bit'(d), 2, wv[wi]);
        end

    // R1: a short excursion is rejected, a long enough one is accepted
    clr(); x4_sel = 1'b1; pulse_len = 8'd2; exp_w = 2;
    step(2'b01, FL - 1);
    step(2'b00, 30);
    check("R1", "glitch shorter than filter", n_clk, 0);
    step(2'b01, FL);
    step(2'b01, 30);
    check("R1", "level held for filter length", n_up, 1);
    step(2'b00, 30);
    check("R1", "return step counted down", n_dn, 1);

    // R9: the second of two close steps is queued
    clr(); pulse_len = 8'd5; exp_w = 5;
    step(2'b01, 3);
    step(2'b11, 40);
    step(2'b10, 3);
    step(2'b00, 40);
    check("R9", "queued steps all emitted", n_up, 4);
    check("R9", "queued pulse widths", width_bad, 0);
    check("R9", "direction during queue", dir_bad, 0);

    // R10: both lines change together
    clr(); pulse_len = 8'd2; exp_w = 2;
    step(2'b11, 30);
    check("R10", "error flagged", n_err, 1);
    check("R10", "no pulse on double change", n_clk, 0);
    step(2'b00, 30);
    check("R10", "second error flagged", n_err, 2);
    check("R10", "error lasts one cycle", err_long, 0);
    check("R10", "still no pulse", n_clk, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule